// File: doc/BRIEF.md
# Pulse Accumulator

An 8-bit counter fed from one external pin. In event mode every active transition on the pin adds one to the count. In gated mode a free-running divide-by-64 tick of the system clock adds one to the count. This happens only while the pin sits at its active level, so the count measures how long the pin stayed active. Software can load the count at any moment, and the count is always visible on an output.

The pin is asynchronous. It passes through a two-flop synchroniser, and all edge detection is done on the synchronised level. One polarity bit picks the active edge in event mode, or the active level in gated mode. Two status flags are kept. The overflow flag sets when an increment wraps the count from 0xFF to 0x00. The input flag sets on each counted edge in event mode, or when the gate goes from its active level to its inactive level in gated mode. Each flag has its own interrupt enable, and writing a 1 to a flag's bit clears that flag.

Top module: `pulse_acc`

## Requirements
- R1: After reset the count is 0x00, both flags are 0 and both interrupt outputs are 0.
- R2: A count write loads `cnt_wdata_i` into the count on the next clock edge. This holds in either mode and whether or not the block is enabled.
- R3: In event mode (`mode_i`=0), each active pin edge adds one to the count, wrapping from 0xFF to 0x00. The active edge is rising when `pol_i`=0 and falling when `pol_i`=1; the other edge has no effect. A pin change set up before clock edge N shows in the count after edge N+2.
- R4: In gated mode (`mode_i`=1), the count rises by one on every 64th clock edge while the synchronised pin is at its active level (high when `pol_i`=0, low when `pol_i`=1). The 64-edge tick runs freely from reset, so any run of 64·k consecutive active edges adds exactly k.
- R5: The overflow flag (clear-mask bit 0) sets when an increment moves the count from 0xFF to 0x00. This applies in both modes.
- R6: The input flag (clear-mask bit 1) sets on each active edge in event mode. In gated mode it sets only on the move from the active level to the inactive level, never on the move into the active level.
- R7: `ovf_irq_o` equals the overflow flag AND `ovf_ie_i`, and `edge_irq_o` equals the input flag AND `edge_ie_i`.
- R8: A pulse on `flag_clr_i` clears each flag whose bit in `flag_wdata_i` is 1 and leaves the other flag unchanged. If a flag's set event falls in the same cycle as its clear, the flag stays set.
- R9: If a count write falls in the same cycle as an increment, the written value wins. The lost increment does not set the overflow flag.
- R10: With `en_i`=0 the pin neither changes the count nor sets any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (E) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous accumulator input pin |
| en_i | input | 1 | Accumulator enable |
| mode_i | input | 1 | 0 = event counting, 1 = gated time accumulation |
| pol_i | input | 1 | 0 = rising edge / high gate, 1 = falling edge / low gate |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| edge_ie_i | input | 1 | Input interrupt enable |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 8 | Count write data |
| flag_clr_i | input | 1 | Flag clear strobe |
| flag_wdata_i | input | 2 | Clear mask: bit 0 overflow, bit 1 input |
| cnt_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Overflow flag |
| edge_flag_o | output | 1 | Input flag |
| ovf_irq_o | output | 1 | Masked overflow interrupt |
| edge_irq_o | output | 1 | Masked input interrupt |

## Verification
Two pairs of actions can meet in the same cycle: a software count write with a pin-driven increment, and a flag clear with that flag's set event. The bench raises the pin at a known falling clock edge and counts two synchroniser stages. It then asserts the write strobe, or in a separate case the clear strobe, for exactly the edge on which the increment lands. In the write case the count must hold the written value rather than value+1, and an increment that would have wrapped 0xFF must leave the overflow flag clear. In the clear case the input flag must still read 1 while the count still advances.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic {
    PA_EVENT = 1'b0,
    PA_GATED = 1'b1
  } pa_mode_e;

  localparam int unsigned FLAG_OVF  = 0;
  localparam int unsigned FLAG_EDGE = 1;
  localparam int unsigned FLAG_N    = 2;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], pin_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign lvl_o  = sr_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

  // an edge is reported for one cycle only
  assert_rise_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  assert_fall_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + DW'(1);
      end

      assign tick_o = (div_q == LAST);

      assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic [W-1:0] cnt_q;

  // software write outranks the increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (wr_i)  cnt_q <= wr_data_i;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
  assign ovf_o = inc_i & ~wr_i & (cnt_q == MAXV);

  assert_write_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wr_data_i));
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i) |=> cnt_o == $past(cnt_o) + W'(1));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(cnt_o));
  assert_no_ovf_on_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !ovf_o);
endmodule

// File: rtl/pa_flags.sv
module pa_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] flag_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> flag_o[i]);
      assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
      assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i[i] && flag_o[i]) |=> flag_o[i]);
    end
  endgenerate
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pa_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned GATE_DIV    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic             ovf_ie_i,
  input  logic             edge_ie_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             flag_clr_i,
  input  logic [1:0]       flag_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_flag_o,
  output logic             edge_flag_o,
  output logic             ovf_irq_o,
  output logic             edge_irq_o
);
  pa_mode_e mode;
  logic lvl, rise, fall, tick;
  logic gate_on, lead_edge, trail_edge;
  logic inc, ovf_evt, edge_evt;
  logic [FLAG_N-1:0] set_v, clr_v, ie_v, flag_v, irq_v;

  assign mode = pa_mode_e'(mode_i);

  pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  pa_prescale #(.DIV(GATE_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  // polarity folds edge and level selection into one bit
  assign gate_on    = lvl ^ pol_i;
  assign lead_edge  = pol_i ? fall : rise;
  assign trail_edge = pol_i ? rise : fall;

  always_comb begin
    inc      = 1'b0;
    edge_evt = 1'b0;
    if (en_i) begin
      unique case (mode)
        PA_EVENT: begin
          inc      = lead_edge;
          edge_evt = lead_edge;
        end
        PA_GATED: begin
          inc      = tick & gate_on;
          edge_evt = trail_edge;
        end
        default: ;
      endcase
    end
  end

  pa_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cnt_wr_i),
    .wr_data_i(cnt_wdata_i),
    .inc_i    (inc),
    .cnt_o    (cnt_o),
    .ovf_o    (ovf_evt)
  );

  always_comb begin
    set_v = '0;
    ie_v  = '0;
    set_v[FLAG_OVF]  = ovf_evt;
    set_v[FLAG_EDGE] = edge_evt;
    ie_v[FLAG_OVF]   = ovf_ie_i;
    ie_v[FLAG_EDGE]  = edge_ie_i;
    clr_v = flag_clr_i ? flag_wdata_i : '0;
  end

  pa_flags #(.N(FLAG_N)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (clr_v),
    .ie_i  (ie_v),
    .flag_o(flag_v),
    .irq_o (irq_v)
  );

  assign ovf_flag_o  = flag_v[FLAG_OVF];
  assign edge_flag_o = flag_v[FLAG_EDGE];
  assign ovf_irq_o   = irq_v[FLAG_OVF];
  assign edge_irq_o  = irq_v[FLAG_EDGE];

  assert_off_no_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flag_clr_i) |=> $stable({ovf_flag_o, edge_flag_o}));
  assert_off_no_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr_i) |=> $stable(cnt_o));
  assert_ovf_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> (cnt_o == '0) && ovf_flag_o);
endmodule

// File: tb/pulse_acc_tb.sv
module pulse_acc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, en = 1'b0, mode = 1'b0, pol = 1'b0;
  logic       ovf_ie = 1'b0, edge_ie = 1'b0;
  logic       cnt_wr = 1'b0, flag_clr = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [1:0] flag_wdata = '0;
  logic [7:0] cnt;
  logic       ovf_flag, edge_flag, ovf_irq, edge_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_acc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .en_i(en), .mode_i(mode),
    .pol_i(pol), .ovf_ie_i(ovf_ie), .edge_ie_i(edge_ie),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
    .flag_clr_i(flag_clr), .flag_wdata_i(flag_wdata),
    .cnt_o(cnt), .ovf_flag_o(ovf_flag), .edge_flag_o(edge_flag),
    .ovf_irq_o(ovf_irq), .edge_irq_o(edge_irq)
  );

  typedef struct {
    logic [7:0] cnt;
    bit         chk_cnt;
    logic       ovf, edg, oirq, eirq;
    string      tag;
  } exp_t;

  exp_t sb[$];
  event push_ev;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(push_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if ((e.chk_cnt && cnt !== e.cnt) || ovf_flag !== e.ovf || edge_flag !== e.edg ||
            ovf_irq !== e.oirq || edge_irq !== e.eirq) begin
          errors++;
          $display("FAIL %s: cnt=%h ovf=%b edg=%b oirq=%b eirq=%b expected cnt=%h(chk=%0d) ovf=%b edg=%b oirq=%b eirq=%b",
                   e.tag, cnt, ovf_flag, edge_flag, ovf_irq, edge_irq,
                   e.cnt, e.chk_cnt, e.ovf, e.edg, e.oirq, e.eirq);
        end
      end
    end
  end

  task automatic expect_st(input logic [7:0] c, input bit chk, input logic o, input logic g,
                           input string tag);
    exp_t e;
    e.cnt = c; e.chk_cnt = chk; e.ovf = o; e.edg = g;
    e.oirq = o & ovf_ie; e.eirq = g & edge_ie; e.tag = tag;
    sb.push_back(e);
    -> push_ev;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    step(1);
    cnt_wr = 1'b0;
  endtask

  task automatic clr(input logic [1:0] m);
    flag_clr = 1'b1; flag_wdata = m;
    step(1);
    flag_clr = 1'b0; flag_wdata = '0;
  endtask

  // n pulses at the active level for the current polarity
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin = ~pol; step(4);
      pin = pol;  step(4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_st(8'h00, 1, 0, 0, "R1 reset state");
    rst_n = 1'b1;
    step(2);
    expect_st(8'h00, 1, 0, 0, "R1 after reset release");

    // disabled: pin ignored
    pulses(3);
    expect_st(8'h00, 1, 0, 0, "R10 disabled pulses ignored");
    wr_cnt(8'h5A);
    expect_st(8'h5A, 1, 0, 0, "R2 write while disabled");

    // event mode, rising edges
    en = 1'b1;
    pulses(3);
    expect_st(8'h5D, 1, 0, 1, "R3 R6 three rising edges");
    edge_ie = 1'b1; step(1);
    expect_st(8'h5D, 1, 0, 1, "R7 input irq enabled");
    clr(2'b10);
    expect_st(8'h5D, 1, 0, 0, "R8 clear input flag");

    // wrap
    wr_cnt(8'hFE);
    pulses(2);
    expect_st(8'h00, 1, 1, 1, "R3 R5 wrap sets overflow");
    ovf_ie = 1'b1; step(1);
    expect_st(8'h00, 1, 1, 1, "R7 overflow irq enabled");
    clr(2'b01);
    expect_st(8'h00, 1, 0, 1, "R8 clear overflow only");
    clr(2'b10);

    // falling polarity; rising edge must be ignored
    pol = 1'b1; step(1);
    pin = 1'b1; step(4);
    expect_st(8'h00, 1, 0, 0, "R3 inactive edge ignored");
    pulses(2);
    expect_st(8'h02, 1, 0, 1, "R3 falling edges counted");

    // write vs increment in same cycle
    pol = 1'b0; step(1);
    pin = 1'b0; step(4);
    wr_cnt(8'hFF);
    clr(2'b11);
    pin = 1'b1;
    step(2);
    cnt_wr = 1'b1; cnt_wdata = 8'h33;
    step(1);
    cnt_wr = 1'b0;
    step(2);
    expect_st(8'h33, 1, 0, 1, "R9 write beats increment, no overflow");
    pin = 1'b0; step(4);

    // gated mode, high gate
    mode = 1'b1;
    clr(2'b11);
    wr_cnt(8'h10);
    pin = 1'b1;
    step(8);
    expect_st(8'h00, 0, 0, 0, "R6 leading gate edge sets no flag");
    step(120);
    pin = 1'b0;
    step(4);
    expect_st(8'h12, 1, 0, 1, "R4 R6 gate 128 cycles adds 2");

    // gated mode, low gate
    en = 1'b0;
    pin = 1'b1; step(4);
    pol = 1'b1;
    clr(2'b11);
    wr_cnt(8'h00);
    en = 1'b1;
    step(1);
    expect_st(8'h00, 1, 0, 0, "R10 disabled gate changes ignored");
    pin = 1'b0;
    step(192);
    pin = 1'b1;
    step(4);
    expect_st(8'h03, 1, 0, 1, "R4 low gate 192 cycles adds 3");

    // gated wrap
    clr(2'b11);
    wr_cnt(8'hFF);
    pin = 1'b0;
    step(64);
    pin = 1'b1;
    step(4);
    expect_st(8'h00, 1, 1, 1, "R5 gated wrap sets overflow");

    // set wins over clear in same cycle
    en = 1'b0; mode = 1'b0; pol = 1'b0;
    pin = 1'b0; step(4);
    en = 1'b1;
    clr(2'b11);
    wr_cnt(8'h40);
    pin = 1'b1;
    step(2);
    flag_clr = 1'b1; flag_wdata = 2'b10;
    step(1);
    flag_clr = 1'b0; flag_wdata = '0;
    step(2);
    expect_st(8'h41, 1, 0, 1, "R8 set wins over clear");
    pin = 1'b0; step(4);

    ovf_ie = 1'b0; edge_ie = 1'b0; step(1);
    expect_st(8'h41, 1, 0, 1, "R7 irqs masked off");

    done = 1'b1;
    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule